// File: doc/BRIEF.md
# Dual Serial ADC Sequenced Reader

This controller runs a sampling cycle on two 16-bit serial converters that share one convert strobe, one serial clock and one data return line. Each converter has its own active-low select input. A start request raises the convert strobe while both selects stay high. The controller then waits a fixed worst-case conversion window. After that it reads the two converters one after the other.

For each read the controller lowers that converter's select line. The most significant bit is then already on the data line. The controller produces 16 serial-clock pulses and takes one bit on each falling edge it generates. It then raises the select line again. After both words are in, the convert strobe drops and a one-cycle strobe presents both words together.

All timing values are parameters counted in system-clock cycles: the conversion wait, the serial-clock half period and the gap between the two reads.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, and while reset is held, `cnv`, `sck`, `busy` and `valid` are 0 and `sel_n` is 2'b11.
- R2: A `start` seen while idle makes `cnv` high on the next cycle, with `sel_n` still 2'b11.
- R3: Both selects stay high for exactly CONV_CYC cycles after `cnv` rises. Then `sel_n[0]` falls.
- R4: Converter 0 (`sel_n[0]`) is read before converter 1 (`sel_n[1]`). The two selects are never low at the same time.
- R5: Each select-low window contains exactly 16 rising edges of `sck`. `sck` is low whenever no select is low.
- R6: Each result word is assembled MSB first. It takes the level of `sdo` at every controller-driven falling edge of `sck`: bit 15 at the first fall, bit 0 at the 16th.
- R7: `cnv` stays high from its rise until the second read ends, while any select is low.
- R8: `valid` is high for exactly one cycle. It rises in the same cycle as `sel_n[1]` returns high and `cnv` falls. `word0` and `word1` change only in that cycle.
- R9: A `start` that arrives while `busy` is high has no effect. No further conversion follows the current one.
- R10: `sel_n[1]` falls exactly GAP_CYC cycles after `sel_n[0]` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one sampling cycle |
| sdo | input | 1 | Shared serial data from the converters |
| cnv | output | 1 | Shared convert strobe |
| sck | output | 1 | Shared serial clock |
| sel_n | output | 2 | Active-low selects, bit 0 for converter 0 |
| busy | output | 1 | A sampling cycle is in progress |
| valid | output | 1 | One-cycle result strobe |
| word0 | output | DATA_W | Result from converter 0 |
| word1 | output | DATA_W | Result from converter 1 |

## Verification
- **Counter faults:** a wrong cycle or bit counter shows up directly at the ports. The select edge moves off its cycle, or a window holds 15 or 17 clock pulses. Either shows within one conversion cycle, at the first select edge or the first frame end.
- **Shift or capture faults:** a wrong shift or capture point gives a bit-rotated or swapped word when `valid` rises.
- **Sequencer faults:** a state machine that leaves idle on the wrong event restarts the strobe while the bench expects silence. This is caught a few cycles after the extra `start`.

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 60,
  parameter int SCK_HALF = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sdo,
  output logic              cnv,
  output logic              sck,
  output logic [1:0]        sel_n,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1
);
  localparam int MAX_AB = (CONV_CYC > SCK_HALF) ? CONV_CYC : SCK_HALF;
  localparam int MAXC   = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int BW     = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_LOW, S_HIGH, S_GAP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbits;
  logic             dev;
  logic [DATA_W-1:0] sh, hold;

  wire tick = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nbits <= '0;
      dev   <= 1'b0;
      sh    <= '0;
      hold  <= '0;
      cnv   <= 1'b0;
      sck   <= 1'b0;
      sel_n <= 2'b11;
      valid <= 1'b0;
      word0 <= '0;
      word1 <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cnv <= 1'b1;
          cnt <= CW'(CONV_CYC - 1);
          st  <= S_CONV;
        end
        S_CONV: if (tick) begin
          sel_n <= 2'b10;
          dev   <= 1'b0;
          nbits <= '0;
          cnt   <= CW'(SCK_HALF - 1);
          st    <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (tick) begin
          if (nbits == BW'(DATA_W)) begin
            sel_n <= 2'b11;
            if (!dev) begin
              hold <= sh;
              cnt  <= CW'(GAP_CYC - 1);
              st   <= S_GAP;
            end else begin
              word0 <= hold;
              word1 <= sh;
              valid <= 1'b1;
              cnv   <= 1'b0;
              st    <= S_IDLE;
            end
          end else begin
            sck <= 1'b1;
            cnt <= CW'(SCK_HALF - 1);
            st  <= S_HIGH;
          end
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (tick) begin
          sck   <= 1'b0;
          sh    <= {sh[DATA_W-2:0], sdo};
          nbits <= nbits + 1'b1;
          cnt   <= CW'(SCK_HALF - 1);
          st    <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (tick) begin
          dev   <= 1'b1;
          sel_n <= 2'b01;
          nbits <= '0;
          cnt   <= CW'(SCK_HALF - 1);
          st    <= S_LOW;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  start_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (cnv && sel_n == 2'b11));
  // R3
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> (cnv && sel_n == 2'b11 && !sck));
  // R4
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);
  // R5
  sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (sel_n != 2'b11));
  // R7
  cnv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != 2'b11) |-> cnv);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(word0) && $stable(word1)));
endmodule

// File: tb/test_dual_adc_reader.sv
`timescale 1ns/100ps
module test_dual_adc_reader;
  localparam int CONV = 7, HALF = 2, GAP = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic cnv, sck, busy, valid;
  logic [1:0] sel_n;
  logic [15:0] word0, word1;
  logic [15:0] mw0 = 0, mw1 = 0, m_sh = 0;
  wire sdo = m_sh[15];
  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_adc_reader #(.DATA_W(16), .CONV_CYC(CONV), .SCK_HALF(HALF), .GAP_CYC(GAP)) i_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo), .cnv(cnv), .sck(sck),
    .sel_n(sel_n), .busy(busy), .valid(valid), .word0(word0), .word1(word1));

  always @(negedge sel_n[0]) m_sh = mw0;
  always @(negedge sel_n[1]) m_sh = mw1;
  always @(negedge sck) #1 m_sh = {m_sh[14:0], 1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  task automatic run_cycle(input logic [15:0] a, input logic [15:0] b, input bit extra_start);
    int n, rises;
    bit prev, bad;
    mw0 = a; mw1 = b;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(cnv && sel_n == 2'b11, "R2", {cnv, sel_n}, 3'b111);
    n = 0; bad = 0;
    do begin
      @(negedge clk); n++;
      if (extra_start && n == 2) start = 1; else start = 0;
      if (sel_n[0] && sel_n != 2'b11) bad = 1;
    end while (sel_n[0]);
    start = 0;
    chk(n == CONV && !bad, "R3", n, CONV);
    rises = 0; prev = 0; bad = 0;
    do begin
      @(negedge clk);
      if (sck && !prev) rises++;
      prev = sck;
      if (!sel_n[1]) bad = 1;
    end while (!sel_n[0]);
    chk(rises == 16, "R5", rises, 16);
    chk(!bad, "R4", sel_n, 2'b11);
    n = 0;
    do begin @(negedge clk); n++; end while (sel_n[1]);
    chk(n == GAP, "R10", n, GAP);
    rises = 0; prev = 0; bad = 0;
    do begin
      @(negedge clk);
      if (sck && !prev) rises++;
      prev = sck;
      if (!sel_n[1] && !cnv) bad = 1;
    end while (!sel_n[1]);
    chk(rises == 16, "R5", rises, 16);
    chk(!bad, "R7", cnv, 1);
    chk(valid && !cnv, "R8", {valid, cnv}, 2'b10);
    chk(word0 == a, "R6", word0, a);
    chk(word1 == b, "R6", word1, b);
    @(negedge clk);
    chk(!valid && word0 == a && word1 == b, "R8", valid, 0);
  endtask

  localparam logic [31:0] VEC [5] = '{
    32'hA5C3_3C5A, 32'h0001_8000, 32'hFFFF_0000, 32'h1234_FEDC, 32'h8001_7FFE};

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset held
    chk(!cnv && !sck && !busy && !valid && sel_n == 2'b11, "R1", {cnv, sck, busy, valid, sel_n}, 6'b000011);
    rst_n = 1;
    @(negedge clk);
    chk(!cnv && sel_n == 2'b11 && !busy, "R1", {cnv, sel_n, busy}, 4'b0110);
    foreach (VEC[i]) run_cycle(VEC[i][31:16], VEC[i][15:0], 0);
    // R9 start during busy is ignored
    run_cycle(16'h5A5A, 16'hC0DE, 1);
    repeat (10) @(negedge clk);
    chk(!cnv && !busy && sel_n == 2'b11, "R9", {cnv, busy}, 0);
    // R1 reset in the middle of a read
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (CONV + 12) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!cnv && !sck && !busy && sel_n == 2'b11, "R1", {cnv, sck, busy, sel_n}, 5'b00011);
    rst_n = 1;
    @(negedge clk);
    run_cycle(16'h0F0F, 16'hF00F, 0);
    finish_run();
  end
endmodule